// File: doc/BRIEF.md
# Coherence Invalidate Queue

This block sits between the coherence interconnect and one cache's line-state array. Remote invalidate messages are acknowledged in the same cycle they arrive and are parked in an ordered queue. The queue is then drained into the state array, at most one line per cycle. Local loads never look into the queue, so a line whose invalidation is still pending keeps its old state until the queue reaches it.

When an invalidation reaches a dirty line, the block asks for a write-back first. It holds the line address steady until that write-back is acknowledged, and only then marks the line Invalid. A read-barrier request completes once every invalidation accepted before the request has been written to the state array. Invalidations that arrive after the request do not hold the barrier back.

The state array is outside the block and is read combinationally. The block presents the head entry's set index and gets back that set's stored tag and state. An address splits into a low set-index field and a high tag field.

Top module: `coh_invq`

## Requirements
- R1: While the queue holds fewer than DEPTH entries, an incoming invalidate (`inv_valid_i` high) is acknowledged in the same cycle and is queued.
- R2: While the queue holds DEPTH entries, `inv_ack_o` stays low and the offered invalidate is not taken, so that line's state is never changed by it.
- R3: Queued invalidations reach the state array in arrival order, with no more than one state write per clock cycle.
- R4: Line states are coded Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. The set index is `addr[IDX_W-1:0]` and the tag is `addr[ADDR_W-1:IDX_W]`. An entry writes Invalid to its set only when the stored tag equals the entry's tag and the stored state is not Invalid; otherwise it retires with no write.
- R5: An entry that hits a Modified line raises `wb_req_o` with the full line address on `wb_addr_o`, holds both until `wb_ack_i`, and writes Invalid in the cycle `wb_ack_i` is seen, not before.
- R6: A line whose invalidation is queued but not yet retired keeps its prior state in the array.
- R7: After `bar_req_i` rises, `bar_done_o` pulses for one cycle once every entry that was queued at the request edge has retired; with an empty queue this is the cycle after the request.
- R8: After reset the queue is empty, and `st_wr_en_o`, `wb_req_o` and `bar_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_valid_i | input | 1 | Invalidate message offered |
| inv_addr_i | input | ADDR_W | Line address of the message |
| inv_ack_o | output | 1 | Message accepted this cycle |
| st_rd_idx_o | output | IDX_W | Set index being looked up |
| st_rd_tag_i | input | ADDR_W-IDX_W | Stored tag of that set |
| st_rd_state_i | input | 2 | Stored state of that set |
| st_wr_en_o | output | 1 | State write strobe |
| st_wr_idx_o | output | IDX_W | Set index written |
| st_wr_state_o | output | 2 | State value written |
| wb_req_o | output | 1 | Write-back of a dirty line requested |
| wb_addr_o | output | ADDR_W | Address of the line to write back |
| wb_ack_i | input | 1 | Write-back accepted |
| bar_req_i | input | 1 | Read-barrier request, held until done |
| bar_done_o | output | 1 | Barrier complete (one-cycle pulse) |

## Verification
The properties take for granted that `wb_ack_i` is asserted only while `wb_req_o` is high, and that `bar_req_i` stays high until `bar_done_o` and then drops. They also assume the state-array read answers combinationally for the index presented. The bench meets these conditions in three ways. It gates its write-back acknowledge with `wb_req_o`. It lowers the barrier request in the clock edge that follows the observed pulse. It models the array as a lookup indexed by `st_rd_idx_o`, updated only at clock edges.

// File: rtl/coh_invq_pkg.sv
package coh_invq_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHR = 2'b01,
    LN_EXC = 2'b10,
    LN_MOD = 2'b11
  } line_state_e;
endpackage

// File: rtl/coh_invq_fifo.sv
module coh_invq_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic             full_o,
  output logic             empty_o,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push_i ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_i  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && (wr_ptr_q == PTR_W'(g))) slot_q[g] <= data_i;
    end
  end

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/coh_invq_apply.sv
module coh_invq_apply
  import coh_invq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [1:0]        rd_state_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [1:0]        wr_state_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i,
  output logic              retire_o
);
  logic wb_wait_q, wb_wait_d;
  logic hit;

  assign rd_idx_o = head_addr_i[IDX_W-1:0];
  assign hit = head_valid_i && (rd_tag_i == head_addr_i[ADDR_W-1:IDX_W])
               && (line_state_e'(rd_state_i) != LN_INV);

  always_comb begin
    wb_wait_d = wb_wait_q;
    wr_en_o   = 1'b0;
    retire_o  = 1'b0;
    if (wb_wait_q) begin
      if (wb_ack_i) begin
        wr_en_o   = 1'b1;
        retire_o  = 1'b1;
        wb_wait_d = 1'b0;
      end
    end else if (head_valid_i) begin
      if (hit && (line_state_e'(rd_state_i) == LN_MOD)) begin
        wb_wait_d = 1'b1;
      end else begin
        wr_en_o  = hit;
        retire_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wb_wait_q <= 1'b0;
    else        wb_wait_q <= wb_wait_d;
  end

  assign wr_idx_o   = head_addr_i[IDX_W-1:0];
  assign wr_state_o = LN_INV;
  assign wb_req_o   = wb_wait_q;
  assign wb_addr_o  = head_addr_i;
endmodule

// File: rtl/coh_invq_barrier.sv
module coh_invq_barrier #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] occupancy_i,
  input  logic             retire_i,
  output logic             done_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             left_en;

  always_comb begin
    busy_d  = busy_q;
    left_d  = left_q;
    left_en = 1'b0;
    if (!busy_q) begin
      if (req_i) begin
        busy_d  = 1'b1;
        left_en = 1'b1;
        left_d  = occupancy_i - CNT_W'(retire_i);
      end
    end else if (left_q == '0) begin
      busy_d = 1'b0;
    end else if (retire_i) begin
      left_en = 1'b1;
      left_d  = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (left_en) left_q <= left_d;
    end
  end

  assign done_o = busy_q && (left_q == '0);
endmodule

// File: rtl/coh_invq.sv
module coh_invq #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DEPTH  = 4,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_valid_i,
  input  logic [ADDR_W-1:0] inv_addr_i,
  output logic              inv_ack_o,
  output logic [IDX_W-1:0]  st_rd_idx_o,
  input  logic [TAG_W-1:0]  st_rd_tag_i,
  input  logic [1:0]        st_rd_state_i,
  output logic              st_wr_en_o,
  output logic [IDX_W-1:0]  st_wr_idx_o,
  output logic [1:0]        st_wr_state_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i,
  input  logic              bar_req_i,
  output logic              bar_done_o
);
  logic              q_full, q_empty, q_retire;
  logic [ADDR_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count;

  assign inv_ack_o = inv_valid_i && !q_full;

  coh_invq_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(inv_ack_o), .data_i(inv_addr_i), .pop_i(q_retire),
    .full_o(q_full), .empty_o(q_empty), .head_o(q_head), .count_o(q_count)
  );

  coh_invq_apply #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) apply_i (
    .clk(clk), .rst_n(rst_n),
    .head_valid_i(!q_empty), .head_addr_i(q_head),
    .rd_idx_o(st_rd_idx_o), .rd_tag_i(st_rd_tag_i), .rd_state_i(st_rd_state_i),
    .wr_en_o(st_wr_en_o), .wr_idx_o(st_wr_idx_o), .wr_state_o(st_wr_state_o),
    .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o), .wb_ack_i(wb_ack_i),
    .retire_o(q_retire)
  );

  coh_invq_barrier #(.DEPTH(DEPTH)) barrier_i (
    .clk(clk), .rst_n(rst_n),
    .req_i(bar_req_i), .occupancy_i(q_count), .retire_i(q_retire),
    .done_o(bar_done_o)
  );
endmodule

// File: rtl/coh_invq_chk.sv
module coh_invq_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inv_valid_i,
  input logic              inv_ack_o,
  input logic [CNT_W-1:0]  q_count,
  input logic              st_wr_en_o,
  input logic [1:0]        st_wr_state_o,
  input logic              wb_req_o,
  input logic              wb_ack_i,
  input logic [ADDR_W-1:0] wb_addr_o,
  input logic              bar_done_o
);
  assert_ack_with_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid_i && (q_count < CNT_W'(DEPTH))) |-> inv_ack_o);

  assert_no_ack_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CNT_W'(DEPTH)) |-> !inv_ack_o);

  assert_ack_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack_o |-> inv_valid_i);

  assert_write_is_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en_o |-> (st_wr_state_o == 2'b00));

  assert_no_write_during_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i) |-> !st_wr_en_o);

  assert_wb_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_addr_o)));

  assert_wb_ack_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && wb_ack_i) |-> st_wr_en_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done_o |=> !bar_done_o);
endmodule

bind coh_invq coh_invq_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .inv_valid_i(inv_valid_i), .inv_ack_o(inv_ack_o),
  .q_count(q_count), .st_wr_en_o(st_wr_en_o), .st_wr_state_o(st_wr_state_o),
  .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i), .wb_addr_o(wb_addr_o),
  .bar_done_o(bar_done_o)
);

// File: tb/coh_invq_tb_top.sv
module coh_invq_tb_top;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int NVEC   = 8;

  // {pre_state, pre_tag, inv_tag, exp_state, exp_write, exp_wb}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'b01, 12'h012, 12'h012, 2'b00, 1'b1, 1'b0},
    {2'b10, 12'h034, 12'h034, 2'b00, 1'b1, 1'b0},
    {2'b11, 12'h056, 12'h056, 2'b00, 1'b1, 1'b1},
    {2'b01, 12'h078, 12'h079, 2'b01, 1'b0, 1'b0},
    {2'b11, 12'h0AB, 12'h0AC, 2'b11, 1'b0, 1'b0},
    {2'b00, 12'h0CD, 12'h0CD, 2'b00, 1'b0, 1'b0},
    {2'b10, 12'hFFF, 12'hFFF, 2'b00, 1'b1, 1'b0},
    {2'b11, 12'h000, 12'h000, 2'b00, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, inv_valid_i, inv_ack_o, st_wr_en_o, wb_req_o;
  logic              wb_ack_i, bar_req_i, bar_done_o;
  logic [ADDR_W-1:0] inv_addr_i, wb_addr_o;
  logic [IDX_W-1:0]  st_rd_idx_o, st_wr_idx_o;
  logic [TAG_W-1:0]  st_rd_tag_i;
  logic [1:0]        st_rd_state_i, st_wr_state_o;

  logic [1:0]       arr_st  [LINES];
  logic [TAG_W-1:0] arr_tag [LINES];
  logic             pre_en, wb_go;
  logic [IDX_W-1:0] pre_idx;
  logic [1:0]       pre_st;
  logic [TAG_W-1:0] pre_tag;
  int               wr_cnt, wb_cnt;
  logic [IDX_W-1:0] wr_log [16];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  assign st_rd_state_i = arr_st[st_rd_idx_o];
  assign st_rd_tag_i   = arr_tag[st_rd_idx_o];
  assign wb_ack_i      = wb_req_o && wb_go;

  coh_invq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .inv_valid_i(inv_valid_i), .inv_addr_i(inv_addr_i),
    .inv_ack_o(inv_ack_o), .st_rd_idx_o(st_rd_idx_o), .st_rd_tag_i(st_rd_tag_i),
    .st_rd_state_i(st_rd_state_i), .st_wr_en_o(st_wr_en_o), .st_wr_idx_o(st_wr_idx_o),
    .st_wr_state_o(st_wr_state_o), .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o),
    .wb_ack_i(wb_ack_i), .bar_req_i(bar_req_i), .bar_done_o(bar_done_o)
  );

  // Cache state array model: presets and design writes share one process.
  always @(posedge clk) begin
    if (pre_en) begin
      arr_st[pre_idx]  <= pre_st;
      arr_tag[pre_idx] <= pre_tag;
    end else if (st_wr_en_o) begin
      arr_st[st_wr_idx_o] <= st_wr_state_o;
    end
    if (st_wr_en_o) begin
      wr_log[wr_cnt[3:0]] <= st_wr_idx_o;
      wr_cnt <= wr_cnt + 1;
    end
    if (wb_req_o && wb_ack_i) wb_cnt <= wb_cnt + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 100000) begin
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preset(input int idx, input logic [1:0] st, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = IDX_W'(idx); pre_st = st; pre_tag = tag;
    @(posedge clk); #1 pre_en = 1'b0;
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, output bit acc);
    @(negedge clk);
    inv_valid_i = 1'b1; inv_addr_i = a;
    #1 acc = inv_ack_o;
    @(posedge clk); #1 inv_valid_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!bar_done_o && cyc < 1000) begin
      @(negedge clk); cyc++;
    end
    @(posedge clk); #1 bar_req_i = 1'b0;
  endtask

  task automatic barrier(output int cyc);
    @(negedge clk); bar_req_i = 1'b1;
    wait_done(cyc);
  endtask

  initial begin
    bit acc;
    int cyc, w0, b0;
    rst_n = 1'b0; inv_valid_i = 1'b0; inv_addr_i = '0; bar_req_i = 1'b0;
    pre_en = 1'b0; pre_idx = '0; pre_st = '0; pre_tag = '0; wb_go = 1'b1;
    wr_cnt = 0; wb_cnt = 0;
    for (int i = 0; i < LINES; i++) begin
      arr_st[i] = 2'b00; arr_tag[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: reset state
    @(negedge clk);
    check(!st_wr_en_o && !wb_req_o && !bar_done_o && !inv_ack_o, "R8 idle after reset",
          {st_wr_en_o, wb_req_o, bar_done_o, inv_ack_o}, 0);

    // R7: empty-queue barrier completes one cycle after the request
    barrier(cyc);
    check(cyc == 1, "R7 empty barrier latency", cyc, 1);

    // Vector walk: R1, R4, R5
    for (int v = 0; v < NVEC; v++) begin
      logic [29:0] e;
      e = VEC[v];
      preset(v, e[29:28], e[27:16]);
      w0 = wr_cnt; b0 = wb_cnt;
      send({e[15:4], 4'(v)}, acc);
      check(acc, "R1 same-cycle ack", acc, 1);
      barrier(cyc);
      @(negedge clk);
      check(arr_st[v] == e[3:2], "R4 final line state", arr_st[v], e[3:2]);
      check((wr_cnt - w0) == int'(e[1]), "R4 state write count", wr_cnt - w0, e[1]);
      check((wb_cnt - b0) == int'(e[0]), "R5 write-back count", wb_cnt - b0, e[0]);
    end

    // Stall, fill, back-pressure, stale state, ordering: R2 R3 R5 R6 R7
    wb_go = 1'b0;
    preset(9, 2'b11, 12'h001);
    preset(1, 2'b01, 12'h001);
    preset(5, 2'b01, 12'h001);
    preset(3, 2'b10, 12'h001);
    preset(7, 2'b01, 12'h001);
    w0 = wr_cnt;
    send(16'h0019, acc);
    check(acc, "R1 ack of dirty-line entry", acc, 1);
    send(16'h0011, acc);
    send(16'h0015, acc);
    send(16'h0013, acc);
    check(acc, "R1 ack of fourth entry", acc, 1);
    send(16'h0017, acc);
    check(!acc, "R2 ack withheld when full", acc, 0);
    @(negedge clk);
    check(wb_req_o && wb_addr_o == 16'h0019, "R5 write-back request and address",
          wb_addr_o, 16'h0019);
    check(arr_st[9] == 2'b11, "R5 dirty line not invalidated before ack", arr_st[9], 3);
    check(arr_st[1] == 2'b01 && arr_st[5] == 2'b01 && arr_st[3] == 2'b10,
          "R6 queued lines keep their state", {arr_st[1], arr_st[5], arr_st[3]}, 6'b010110);
    bar_req_i = 1'b1;
    repeat (5) @(negedge clk);
    check(!bar_done_o, "R7 barrier held by pending entries", bar_done_o, 0);
    wb_go = 1'b1;
    wait_done(cyc);
    @(negedge clk);
    check((wr_cnt - w0) == 4, "R3 write count after drain", wr_cnt - w0, 4);
    check(wr_log[(w0 + 0) % 16] == 9 && wr_log[(w0 + 1) % 16] == 1 &&
          wr_log[(w0 + 2) % 16] == 5 && wr_log[(w0 + 3) % 16] == 3,
          "R3 arrival order", {wr_log[(w0 + 0) % 16], wr_log[(w0 + 1) % 16],
          wr_log[(w0 + 2) % 16], wr_log[(w0 + 3) % 16]}, 16'h9153);
    check(arr_st[9] == 0 && arr_st[1] == 0 && arr_st[5] == 0 && arr_st[3] == 0,
          "R6 lines invalid after barrier", {arr_st[9], arr_st[1], arr_st[5], arr_st[3]}, 0);
    check(arr_st[7] == 2'b01, "R2 rejected entry left line untouched", arr_st[7], 1);
    check(!wb_req_o && !st_wr_en_o, "R3 idle after drain", {wb_req_o, st_wr_en_o}, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule